// File: doc/BRIEF.md
# Multi-Lane Deskew Alignment Controller

This block lines up the byte streams of eight receive lanes. The lanes are organised as two quads of four. Every lane feeds an 8-entry elastic FIFO. A lane starts writing into its FIFO when it sees the first alignment marker after it was cleared. A group of lanes that align together keeps its read side closed until every enabled member has captured a marker. The read pointers of the whole group then open on one cycle, so the marker bytes of all members leave the block together and the streams stay in step from then on.

Each lane has a 2-bit mode that sets the group size: none, a pair, a quad, or all eight lanes. Each lane also has an enable that decides whether it takes part in group alignment. Rising edges on resync strobes clear the FIFO pointers of one lane, of a lane pair or of a whole quad. A bypass input per quad routes the raw lane data straight to the outputs. A group whose markers are spread too widely is abandoned, and the block rearms on later markers. The control inputs are plain signals. The block is reset asynchronously with an active-low reset, and that reset is released synchronously.

Top module: `lane_deskew`

## Requirements
- R1: While in reset and right after reset, every lane_aligned_o bit is 0 and lane_data_o is all zeros.
- R2: A lane whose mode is 2'b00 is released on its own. Its aligned bit rises at the clock edge after the edge that captured its marker. It then outputs its own input stream, starting with the marker byte.
- R3: In quad mode (2'b01, lane i uses lane_mode_i[2i+1:2i]), the enabled lanes of a quad all get their aligned bit on the same edge. That edge is the one after the last member captured its marker. From then on each lane outputs its own input stream starting at its marker byte, so the marker bytes leave together.
- R4: In pair mode (2'b10), lanes 2k and 2k+1 form a group, and each pair is released independently of every other pair.
- R5: In eight-lane mode (2'b11), all enabled lanes form one group. A marker skew of 7 cycles between the first and last lane still aligns.
- R6: A lane with lane_en_i at 0 takes no part in group alignment. It is released on its own like a mode 2'b00 lane and does not hold back the enabled members of its group.
- R7: A 0-to-1 edge on lane_resync_i[i] clears lane i at that edge, and its aligned bit is 0 afterwards. Holding the input at 1 has no further effect: the lane re-aligns on its next marker while the input is still 1.
- R8: A 0-to-1 edge on pair_resync_i[k] clears lanes 2k and 2k+1 together and leaves the other lanes aligned.
- R9: A 0-to-1 edge on quad_resync_i[q] clears lanes 4q to 4q+3 together and leaves the other quad aligned.
- R10: While quad_bypass_i[q] is 1, lane_data_o of lanes 4q to 4q+3 equals lane_data_i in the same cycle and their aligned bits are 0. The other quad is unaffected. Those lanes must capture a new marker after bypass ends.
- R11: If a group's last marker arrives 8 or more cycles after its first, the group is not released, because the early FIFOs overflow or the 16-cycle wait expires. A later set of markers inside the window aligns the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data_i | input | 64 | Decoded bytes, lane i in bits [8i+7:8i] |
| lane_mark_i | input | 8 | Alignment-marker flag per lane |
| lane_en_i | input | 8 | Group-alignment participation per lane |
| lane_mode_i | input | 16 | Group size per lane, 2 bits each |
| lane_resync_i | input | 8 | Per-lane resync, rising edge |
| pair_resync_i | input | 4 | Per-pair resync, rising edge |
| quad_resync_i | input | 2 | Per-quad resync, rising edge |
| quad_bypass_i | input | 2 | Per-quad FIFO bypass |
| lane_data_o | output | 64 | Aligned lane bytes |
| lane_aligned_o | output | 8 | Per-lane aligned status |

## Verification
The bench uses the default parameters: two quads of four lanes, 8-byte FIFOs and a 16-cycle marker window. With these values the FIFO limit sits at a 7-cycle skew. The bench therefore tests both the widest skew that still aligns across all eight lanes and a skew of 8 that must fail. Because the quad count is two, every mode can be tested. Pair and quad groups can be released side by side, and resync or bypass on one quad can be shown to leave the other quad untouched.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  typedef enum logic [1:0] {
    LN_WAIT = 2'd0,
    LN_FILL = 2'd1,
    LN_RUN  = 2'd2
  } lane_state_e;

  // Lanes per alignment group for a mode code.
  function automatic int grp_size(input logic [1:0] m);
    case (m)
      2'b10:   return 2;
      2'b01:   return 4;
      2'b11:   return 8;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/deskew_lane.sv
module deskew_lane
  import deskew_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mark_i,
  input  logic              resync_i,
  input  logic              release_i,
  input  logic              abort_i,
  output logic              captured_o,
  output logic              filling_o,
  output logic              aligned_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  lane_state_e       st_q, st_d;
  logic [AW:0]       wp_q, wp_d, rp_q, rp_d, level;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] out_q, out_d;
  logic              wr_en, rd_en;

  assign level = wp_q - rp_q;

  always_comb begin
    st_d  = st_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    out_d = out_q;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (resync_i) begin
      st_d = LN_WAIT;
      wp_d = '0;
      rp_d = '0;
    end else begin
      case (st_q)
        LN_WAIT: if (mark_i) begin
          wr_en = 1'b1;
          st_d  = LN_FILL;
        end
        LN_FILL: begin
          if (release_i) begin
            wr_en = 1'b1;
            rd_en = 1'b1;
            st_d  = LN_RUN;
          end else if (abort_i || level == FULL_LVL) begin
            st_d = LN_WAIT;
            wp_d = '0;
            rp_d = '0;
          end else begin
            wr_en = 1'b1;
          end
        end
        LN_RUN: begin
          wr_en = 1'b1;
          rd_en = 1'b1;
        end
        default: st_d = LN_WAIT;
      endcase
      if (wr_en) wp_d = wp_q + ONE;
      if (rd_en) begin
        rp_d  = rp_q + ONE;
        out_d = mem[rp_q[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_WAIT;
      wp_q  <= '0;
      rp_q  <= '0;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q[AW-1:0]] <= data_i;
  end

  assign captured_o = (st_q != LN_WAIT);
  assign filling_o  = (st_q == LN_FILL);
  assign aligned_o  = (st_q == LN_RUN);
  assign data_o     = out_q;

  // R3: a lane enters the run state only when its group released it
  assert_run_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_RUN && $past(st_q) != LN_RUN) |-> $past(release_i));

  // R11: occupancy never goes past the FIFO depth
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  // R7: a resync always leaves the lane unaligned
  assert_resync_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> !aligned_o);

endmodule

// File: rtl/deskew_group_ctrl.sv
module deskew_group_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int TIMEOUT   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LANES-1:0]   en_i,
  input  logic [2*NUM_LANES-1:0] mode_i,
  input  logic [NUM_LANES-1:0]   captured_i,
  input  logic [NUM_LANES-1:0]   filling_i,
  output logic [NUM_LANES-1:0]   release_o,
  output logic [NUM_LANES-1:0]   abort_o
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [1:0]           mode_a [NUM_LANES];
  logic [NUM_LANES-1:0] part, all_ok, any_fill, pend;
  logic [CW-1:0]        cnt_q [NUM_LANES];
  logic [CW-1:0]        cnt_d [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign mode_a[g] = mode_i[2*g +: 2];
    assign part[g]   = en_i[g] && (mode_i[2*g +: 2] != 2'b00);
  end

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      all_ok[i]   = 1'b1;
      any_fill[i] = 1'b0;
      for (int j = 0; j < NUM_LANES; j++) begin
        if (part[i] && part[j] && mode_a[i] == mode_a[j] &&
            (i / grp_size(mode_a[i])) == (j / grp_size(mode_a[i]))) begin
          all_ok[i]   = all_ok[i] & captured_i[j];
          any_fill[i] = any_fill[i] | filling_i[j];
        end
      end
      release_o[i] = filling_i[i] && (!part[i] || all_ok[i]);
      pend[i]      = part[i] && any_fill[i] && !all_ok[i];
      abort_o[i]   = pend[i] && (cnt_q[i] == CNT_LAST);
      cnt_d[i]     = (pend[i] && !abort_o[i]) ? cnt_q[i] + ONE : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LANES; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  for (genvar a = 0; a < NUM_LANES; a++) begin : g_chk
    // R11: the wait counter never passes the window
    assert_timeout_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[a] <= CNT_LAST);
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_peer
      if (a != b) begin : g_ne
        // R3: members of one group are released together
        assert_group_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (release_o[a] && part[a] && part[b] && mode_a[a] == mode_a[b] &&
           (a / grp_size(mode_a[a])) == (b / grp_size(mode_a[a])) && filling_i[b])
          |-> release_o[b]);
      end
    end
  end

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import deskew_pkg::*;
#(
  parameter int NUM_QUADS      = 2,
  parameter int LANES_PER_QUAD = 4,
  parameter int DATA_W         = 8,
  parameter int FIFO_DEPTH     = 8,
  parameter int SKEW_TIMEOUT   = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_QUADS*LANES_PER_QUAD*DATA_W-1:0] lane_data_i,
  input  logic [NUM_QUADS*LANES_PER_QUAD-1:0]    lane_mark_i,
  input  logic [NUM_QUADS*LANES_PER_QUAD-1:0]    lane_en_i,
  input  logic [2*NUM_QUADS*LANES_PER_QUAD-1:0]  lane_mode_i,
  input  logic [NUM_QUADS*LANES_PER_QUAD-1:0]    lane_resync_i,
  input  logic [NUM_QUADS*LANES_PER_QUAD/2-1:0]  pair_resync_i,
  input  logic [NUM_QUADS-1:0]                   quad_resync_i,
  input  logic [NUM_QUADS-1:0]                   quad_bypass_i,
  output logic [NUM_QUADS*LANES_PER_QUAD*DATA_W-1:0] lane_data_o,
  output logic [NUM_QUADS*LANES_PER_QUAD-1:0]    lane_aligned_o
);

  localparam int NUM_LANES = NUM_QUADS * LANES_PER_QUAD;
  localparam int NUM_PAIRS = NUM_LANES / 2;

  logic [1:0]           rsync_q;
  logic                 rst_core_n;
  logic [NUM_LANES-1:0] lane_rs_q, lane_rise, lane_clr;
  logic [NUM_PAIRS-1:0] pair_rs_q, pair_rise;
  logic [NUM_QUADS-1:0] quad_rs_q, quad_rise;
  logic [NUM_LANES-1:0] captured, filling, release_v, abort_v, lane_al;
  logic [DATA_W-1:0]    lane_q [NUM_LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lane_rs_q <= '0;
      pair_rs_q <= '0;
      quad_rs_q <= '0;
    end else begin
      lane_rs_q <= lane_resync_i;
      pair_rs_q <= pair_resync_i;
      quad_rs_q <= quad_resync_i;
    end
  end

  assign lane_rise = lane_resync_i & ~lane_rs_q;
  assign pair_rise = pair_resync_i & ~pair_rs_q;
  assign quad_rise = quad_resync_i & ~quad_rs_q;

  deskew_group_ctrl #(
    .NUM_LANES (NUM_LANES),
    .TIMEOUT   (SKEW_TIMEOUT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en_i       (lane_en_i),
    .mode_i     (lane_mode_i),
    .captured_i (captured),
    .filling_i  (filling),
    .release_o  (release_v),
    .abort_o    (abort_v)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int Q = i / LANES_PER_QUAD;
    assign lane_clr[i] = lane_rise[i] | pair_rise[i/2] | quad_rise[Q] | quad_bypass_i[Q];

    deskew_lane #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .data_i     (lane_data_i[i*DATA_W +: DATA_W]),
      .mark_i     (lane_mark_i[i]),
      .resync_i   (lane_clr[i]),
      .release_i  (release_v[i]),
      .abort_i    (abort_v[i]),
      .captured_o (captured[i]),
      .filling_o  (filling[i]),
      .aligned_o  (lane_al[i]),
      .data_o     (lane_q[i])
    );

    assign lane_data_o[i*DATA_W +: DATA_W] =
      quad_bypass_i[Q] ? lane_data_i[i*DATA_W +: DATA_W] : lane_q[i];
    assign lane_aligned_o[i] = lane_al[i] & ~quad_bypass_i[Q];
  end

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad_chk
    // R9: a quad resync edge clears all four lanes of that quad
    assert_quad_resync_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
      $rose(quad_resync_i[q]) |=> (lane_al[q*LANES_PER_QUAD +: LANES_PER_QUAD] == '0));
    // R10: bypass keeps the quad's FIFOs out of the run state
    assert_bypass_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
      quad_bypass_i[q] |=> (lane_al[q*LANES_PER_QUAD +: LANES_PER_QUAD] == '0));
  end

endmodule

// File: tb/lane_deskew_tb.sv
`timescale 1ns/100ps
module lane_deskew_tb;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NL*8-1:0] lane_data_i;
  logic [NL-1:0]   lane_mark_i, lane_en_i, lane_resync_i;
  logic [2*NL-1:0] lane_mode_i;
  logic [3:0]      pair_resync_i;
  logic [1:0]      quad_resync_i, quad_bypass_i;
  logic [NL*8-1:0] lane_data_o;
  logic [NL-1:0]   lane_aligned_o;

  always #2.5 clk = ~clk;

  lane_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .lane_data_i(lane_data_i), .lane_mark_i(lane_mark_i),
    .lane_en_i(lane_en_i), .lane_mode_i(lane_mode_i), .lane_resync_i(lane_resync_i),
    .pair_resync_i(pair_resync_i), .quad_resync_i(quad_resync_i),
    .quad_bypass_i(quad_bypass_i), .lane_data_o(lane_data_o),
    .lane_aligned_o(lane_aligned_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;
  logic [7:0] strm [NL];
  bit         armed [NL];
  logic [7:0] sbq [NL][$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: present one byte per lane, push expected output bytes, pass one edge.
  task automatic drive(input logic [NL-1:0] marks);
    for (int i = 0; i < NL; i++) begin
      lane_data_i[i*8 +: 8] = strm[i];
      lane_mark_i[i] = marks[i];
      if (marks[i]) begin
        sbq[i].delete();
        armed[i] = 1'b1;
      end
      if (armed[i]) sbq[i].push_back(strm[i]);
      strm[i] = strm[i] + 8'd1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive('0);
  endtask

  task automatic set_mode(input logic [1:0] m, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) lane_mode_i[2*i +: 2] = m;
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0;
    lane_data_i = '0; lane_mark_i = '0; lane_en_i = '0; lane_mode_i = '0;
    lane_resync_i = '0; pair_resync_i = '0; quad_resync_i = '0; quad_bypass_i = '0;
    for (int i = 0; i < NL; i++) begin
      strm[i] = 8'(i * 37);
      armed[i] = 1'b0;
      sbq[i].delete();
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 aligned in reset", 64'(lane_aligned_o), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    mon_en = 1'b1;
  endtask

  // Monitor: every aligned lane must emit the next expected byte.
  always @(negedge clk) begin
    if (mon_en) begin
      for (int i = 0; i < NL; i++) begin
        if (lane_aligned_o[i]) begin
          if (sbq[i].size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R3 lane %0d aligned with no expected byte actual=%0h expected=none",
                     i, lane_data_o[i*8 +: 8]);
          end else begin
            chk($sformatf("R3 lane %0d data", i), 64'(lane_data_o[i*8 +: 8]),
                64'(sbq[i].pop_front()));
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 aligned after reset", 64'(lane_aligned_o), 64'h0);
    chk("R1 data after reset", lane_data_o, 64'h0);

    // R2 and R6: lanes 4-7 unaligned, lanes 0-2 quad group, lane 3 not enabled
    set_mode(2'b01, 0, 3);
    set_mode(2'b00, 4, 7);
    lane_en_i = 8'hF7;
    drive(8'h11);
    chk("R2 lane4 not yet released", 64'(lane_aligned_o[4]), 64'h0);
    drive(8'h08);
    chk("R2 lane4 released alone", 64'(lane_aligned_o[4]), 64'h1);
    chk("R6 lane3 pending", 64'(lane_aligned_o[3]), 64'h0);
    drive(8'h20);
    chk("R6 lane3 released alone", 64'(lane_aligned_o[3]), 64'h1);
    drive(8'h02);
    drive(8'h00);
    drive(8'h04);
    chk("R3 quad held until last", 64'(lane_aligned_o[2:0]), 64'h0);
    drive(8'h00);
    chk("R3 quad released together", 64'(lane_aligned_o[2:0]), 64'h7);
    chk("R2 lane5 released", 64'(lane_aligned_o[5]), 64'h1);
    idle(12);

    // R3 quad on lanes 0-3, R4 pairs on lanes 4-7
    do_reset();
    set_mode(2'b01, 0, 3);
    set_mode(2'b10, 4, 7);
    lane_en_i = 8'hFF;
    drive(8'h21);
    drive(8'h50);
    chk("R4 pair 4/5 held", 64'(lane_aligned_o[5:4]), 64'h0);
    drive(8'h08);
    chk("R4 pair 4/5 released", 64'(lane_aligned_o[5:4]), 64'h3);
    chk("R4 pair 6/7 held", 64'(lane_aligned_o[7:6]), 64'h0);
    drive(8'h02);
    drive(8'h80);
    chk("R4 pair 6/7 held to last", 64'(lane_aligned_o[7:6]), 64'h0);
    drive(8'h04);
    chk("R4 pair 6/7 released", 64'(lane_aligned_o[7:6]), 64'h3);
    chk("R3 quad held", 64'(lane_aligned_o[3:0]), 64'h0);
    drive(8'h00);
    chk("R3 quad released", 64'(lane_aligned_o[3:0]), 64'hF);
    idle(12);

    // R5 eight-lane group with 7-cycle skew
    do_reset();
    set_mode(2'b11, 0, 7);
    lane_en_i = 8'hFF;
    for (int i = 0; i < NL; i++) drive(8'(1 << i));
    chk("R5 eight held at skew 7", 64'(lane_aligned_o), 64'h0);
    drive(8'h00);
    chk("R5 eight released", 64'(lane_aligned_o), 64'hFF);
    idle(10);

    // R7 lane resync, level held
    lane_resync_i[2] = 1'b1;
    drive(8'h00);
    chk("R7 lane2 cleared", 64'(lane_aligned_o), 64'hFB);
    idle(2);
    chk("R7 held level no effect", 64'(lane_aligned_o), 64'hFB);
    drive(8'h04);
    chk("R7 lane2 captured", 64'(lane_aligned_o), 64'hFB);
    drive(8'h00);
    chk("R7 lane2 realigned while held", 64'(lane_aligned_o), 64'hFF);
    lane_resync_i[2] = 1'b0;
    idle(3);
    chk("R7 falling edge no effect", 64'(lane_aligned_o), 64'hFF);

    // R8 pair resync
    pair_resync_i[2] = 1'b1;
    drive(8'h00);
    chk("R8 pair 2 cleared", 64'(lane_aligned_o), 64'hCF);
    pair_resync_i[2] = 1'b0;
    drive(8'h30);
    chk("R8 pair 2 captured", 64'(lane_aligned_o), 64'hCF);
    drive(8'h00);
    chk("R8 pair 2 realigned", 64'(lane_aligned_o), 64'hFF);

    // R9 quad resync
    quad_resync_i[0] = 1'b1;
    drive(8'h00);
    chk("R9 quad 0 cleared", 64'(lane_aligned_o), 64'hF0);
    quad_resync_i[0] = 1'b0;
    drive(8'h0F);
    chk("R9 quad 0 captured", 64'(lane_aligned_o), 64'hF0);
    drive(8'h00);
    chk("R9 quad 0 realigned", 64'(lane_aligned_o), 64'hFF);
    idle(8);

    // R10 bypass on quad 1
    quad_bypass_i[1] = 1'b1;
    #1;
    chk("R10 bypass aligned", 64'(lane_aligned_o), 64'h0F);
    chk("R10 bypass data", 64'(lane_data_o[63:32]), 64'(lane_data_i[63:32]));
    for (int k = 0; k < 4; k++) begin
      drive(8'h00);
      chk("R10 bypass data per cycle", 64'(lane_data_o[63:32]), 64'(lane_data_i[63:32]));
      chk("R10 other quad aligned", 64'(lane_aligned_o), 64'h0F);
    end
    quad_bypass_i[1] = 1'b0;
    drive(8'h00);
    chk("R10 lanes wait after bypass", 64'(lane_aligned_o), 64'h0F);
    drive(8'hF0);
    chk("R10 captured after bypass", 64'(lane_aligned_o), 64'h0F);
    drive(8'h00);
    chk("R10 realigned after bypass", 64'(lane_aligned_o), 64'hFF);
    idle(8);

    // R11 skew of 8 never aligns; later markers do
    do_reset();
    set_mode(2'b01, 0, 3);
    lane_en_i = 8'h0F;
    drive(8'h07);
    for (int k = 0; k < 7; k++) drive(8'h00);
    drive(8'h08);
    chk("R11 skew 8 held", 64'(lane_aligned_o), 64'h0);
    for (int k = 0; k < 25; k++) begin
      drive(8'h00);
      chk("R11 skew 8 not released", 64'(lane_aligned_o), 64'h0);
    end
    drive(8'h0F);
    chk("R11 new markers captured", 64'(lane_aligned_o), 64'h0);
    drive(8'h00);
    chk("R11 rearmed group aligns", 64'(lane_aligned_o), 64'h0F);
    idle(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule